// File: doc/BRIEF.md
# IDE Bus-Master DMA Channel Register Set

This block holds the software-visible control state for one channel of a PCI IDE bus-master DMA engine. Software reaches it through a small byte-addressed register port. Two 32-bit words carry three registers. The command register selects the transfer direction and starts or stops the engine. The status register holds the event flags, the per-drive DMA-capable flags and the busy flag. The descriptor pointer gives the address of the next 8-byte descriptor that the engine will consume.

On the engine side there is a sideband interface. The block sends start and abort pulses, the direction and the current descriptor address. It receives single-cycle pulses when a descriptor has been fetched, when an interrupt or an error was seen, and when the transfer has completed. Stopping the engine is one-shot. A stopped transfer cannot be resumed, and enabling again begins a new transfer at the pointer's present value.

Byte layout. Word 0 (`reg_addr[2]` = 0) holds the command register in byte 0 and the status register in byte 2. Bytes 1 and 3 of word 0 are unused. Word 1 (`reg_addr[2]` = 1) holds the descriptor pointer. Byte enables pick which bytes of a write take effect.

Top module: `bmdma_chan_regs`

## Requirements
- R1: After reset, both words read 0, and `eng_start`, `eng_abort`, `eng_dir` and `bm_active` are all 0.
- R2: Command byte: bit 3 is the direction (1 = the engine writes to memory) and bit 0 is the enable. The other command bits read 0. Bytes 1 and 3 of word 0 read 0 and ignore writes.
- R3: A write that changes the enable bit from 0 to 1 pulses `eng_start` high for exactly one cycle, starting the cycle after the write. In the same cycle, `bm_active` and status bit 0 become 1.
- R4: A write that changes the enable bit from 1 to 0 pulses `eng_abort` high for exactly one cycle and clears the active flag in that same cycle. Enabling again starts a new transfer, and `eng_prd_addr` continues from the pointer's current value.
- R5: An `eng_done` pulse clears the active flag. The enable bit keeps its value.
- R6: While the active flag is 1, a write to direction bit 3 is ignored. While the flag is 0, the bit is writable.
- R7: `eng_irq_evt` sets status bit 2 and `eng_err_evt` sets status bit 1. Each flag is cleared only by writing 1 to its bit. Writing 0 leaves it unchanged.
- R8: If an event arrives in the same cycle as a write-1 clear of its flag, the flag stays 1.
- R9: Status bits 6 and 5 are read/write drive flags. Bit 7 reflects the `simplex_mode` input. Bits 4:3 read 0. Bit 0 cannot be written.
- R10: The pointer's bits 1:0 always read 0. A write changes only the bytes whose enable bit is set.
- R11: Each `eng_prd_fetched` pulse while active adds 8 to the pointer, one cycle later. Pulses while inactive are ignored. `eng_prd_addr` always equals the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte address; bit 2 selects the word |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| simplex_mode | input | 1 | Simplex indication, shown in status bit 7 |
| eng_prd_fetched | input | 1 | Engine consumed one descriptor |
| eng_irq_evt | input | 1 | Engine saw an interrupt |
| eng_err_evt | input | 1 | Engine saw a transfer error |
| eng_done | input | 1 | Engine finished the transfer |
| eng_start | output | 1 | One-cycle start pulse |
| eng_abort | output | 1 | One-cycle abort pulse |
| eng_dir | output | 1 | Direction (1 = write to memory) |
| eng_prd_addr | output | 32 | Current descriptor address |
| bm_active | output | 1 | Transfer in progress |

## Verification
A wrong enable or active state shows at the engine interface in the cycle after the offending write or event. It appears either as a missing or doubled start or abort pulse, or as `bm_active` disagreeing with status bit 0. A wrong pointer appears on `eng_prd_addr` in the first cycle after a fetch pulse or a byte-enabled write, so each advance is checked against its own step. A flag that was lost or cleared by mistake is visible at the next status read. For this reason the bench reads status right after each event, after each clear, and after each same-cycle collision.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NBYTES = DW / 8;

  // Command byte bit positions
  localparam int unsigned CMD_DIR = 3;
  localparam int unsigned CMD_EN  = 0;

  // Status byte bit positions
  localparam int unsigned STS_SIMPLEX = 7;
  localparam int unsigned STS_DRV1    = 6;
  localparam int unsigned STS_DRV0    = 5;
  localparam int unsigned STS_IRQ     = 2;
  localparam int unsigned STS_ERR     = 1;
  localparam int unsigned STS_ACT     = 0;

  typedef enum logic [0:0] {
    WSEL_CTRL = 1'b0,
    WSEL_PTR  = 1'b1
  } word_sel_e;

  // Step to the next descriptor, keeping the alignment bits cleared
  function automatic logic [DW-1:0] prd_advance(input logic [DW-1:0] cur,
                                                input int unsigned step);
    logic [DW-1:0] nxt;
    nxt = cur + DW'(step);
    nxt[1:0] = 2'b00;
    return nxt;
  endfunction

  // Replace only the bytes whose enable bit is set
  function automatic logic [DW-1:0] be_merge(input logic [DW-1:0] old_v,
                                             input logic [DW-1:0] new_v,
                                             input logic [NBYTES-1:0] be);
    logic [DW-1:0] r;
    for (int i = 0; i < NBYTES; i++) begin
      r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
    end
    return r;
  endfunction

  // Write-1-to-clear with set priority
  function automatic logic w1c_next(input logic cur, input logic set_ev,
                                    input logic clr_wr);
    return set_ev | (cur & ~clr_wr);
  endfunction
endpackage

// File: rtl/bmdma_cmd_ctrl.sv
module bmdma_cmd_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic [7:0] wdata,
  input  logic       done_i,
  output logic       en_o,
  output logic       dir_o,
  output logic       active_o,
  output logic       start_o,
  output logic       abort_o
);
  import bmdma_pkg::*;

  logic en_q, dir_q, act_q, start_q, abort_q;
  logic en_rise, en_fall, dir_wr_ok;

  assign en_rise   = wr_cmd & wdata[CMD_EN] & ~en_q;
  assign en_fall   = wr_cmd & ~wdata[CMD_EN] & en_q;
  assign dir_wr_ok = wr_cmd & ~act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      start_q <= en_rise;
      abort_q <= en_fall;
      if (wr_cmd) en_q <= wdata[CMD_EN];
      if (dir_wr_ok) dir_q <= wdata[CMD_DIR];
      if (en_rise) act_q <= 1'b1;
      else if (en_fall || done_i) act_q <= 1'b0;
    end
  end

  assign en_o     = en_q;
  assign dir_o    = dir_q;
  assign active_o = act_q;
  assign start_o  = start_q;
  assign abort_o  = abort_q;

  p_start_sets_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> act_q);
  p_start_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  p_abort_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (!act_q && !en_q));
  p_no_start_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && abort_q));
  p_dir_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |-> $stable(dir_q));
  p_done_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !en_rise) |=> !act_q);
endmodule

// File: rtl/bmdma_status.sv
module bmdma_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sts,
  input  logic [7:0] wdata,
  input  logic       simplex_i,
  input  logic       active_i,
  input  logic       irq_evt,
  input  logic       err_evt,
  output logic [7:0] sts_o
);
  import bmdma_pkg::*;

  logic drv1_q, drv0_q, irq_q, err_q;
  logic irq_clr, err_clr;

  assign irq_clr = wr_sts & wdata[STS_IRQ];
  assign err_clr = wr_sts & wdata[STS_ERR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv1_q <= 1'b0;
      drv0_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_sts) begin
        drv1_q <= wdata[STS_DRV1];
        drv0_q <= wdata[STS_DRV0];
      end
      irq_q <= w1c_next(irq_q, irq_evt, irq_clr);
      err_q <= w1c_next(err_q, err_evt, err_clr);
    end
  end

  always_comb begin
    sts_o = '0;
    sts_o[STS_SIMPLEX] = simplex_i;
    sts_o[STS_DRV1]    = drv1_q;
    sts_o[STS_DRV0]    = drv0_q;
    sts_o[STS_IRQ]     = irq_q;
    sts_o[STS_ERR]     = err_q;
    sts_o[STS_ACT]     = active_i;
  end

  p_irq_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> irq_q);
  p_err_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_q);
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/bmdma_prd_ptr.sv
module bmdma_prd_ptr #(
  parameter int unsigned STEP = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ptr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        adv_i,
  output logic [31:0] ptr_o
);
  import bmdma_pkg::*;

  logic [31:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_ptr) ptr_d = be_merge(ptr_q, wdata, be);
    else if (adv_i) ptr_d = prd_advance(ptr_q, STEP);
    ptr_d[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  p_ptr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_ptr) |=> (ptr_q - $past(ptr_q)) == 32'(STEP));
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !wr_ptr) |=> $stable(ptr_q));
endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs #(
  parameter int unsigned PRD_STEP = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        simplex_mode,
  input  logic        eng_prd_fetched,
  input  logic        eng_irq_evt,
  input  logic        eng_err_evt,
  input  logic        eng_done,
  output logic        eng_start,
  output logic        eng_abort,
  output logic        eng_dir,
  output logic [31:0] eng_prd_addr,
  output logic        bm_active
);
  import bmdma_pkg::*;

  word_sel_e   wsel;
  logic        wr_cmd, wr_sts, wr_ptr, adv;
  logic        en_w, dir_w, act_w;
  logic [7:0]  sts_w, cmd_w;
  logic [31:0] ptr_w;

  assign wsel   = word_sel_e'(reg_addr[2]);
  assign wr_cmd = reg_wr & (wsel == WSEL_CTRL) & reg_be[0];
  assign wr_sts = reg_wr & (wsel == WSEL_CTRL) & reg_be[2];
  assign wr_ptr = reg_wr & (wsel == WSEL_PTR) & (|reg_be);
  assign adv    = eng_prd_fetched & act_w;

  bmdma_cmd_ctrl u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(reg_wdata[7:0]),
    .done_i(eng_done), .en_o(en_w), .dir_o(dir_w), .active_o(act_w),
    .start_o(eng_start), .abort_o(eng_abort)
  );

  bmdma_status u_sts (
    .clk(clk), .rst_n(rst_n), .wr_sts(wr_sts), .wdata(reg_wdata[23:16]),
    .simplex_i(simplex_mode), .active_i(act_w), .irq_evt(eng_irq_evt),
    .err_evt(eng_err_evt), .sts_o(sts_w)
  );

  bmdma_prd_ptr #(.STEP(PRD_STEP)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .be(reg_be),
    .wdata(reg_wdata), .adv_i(adv), .ptr_o(ptr_w)
  );

  always_comb begin
    cmd_w = '0;
    cmd_w[CMD_DIR] = dir_w;
    cmd_w[CMD_EN]  = en_w;
  end

  always_comb begin
    if (wsel == WSEL_PTR) reg_rdata = ptr_w;
    else                  reg_rdata = {8'h00, sts_w, 8'h00, cmd_w};
  end

  assign eng_dir      = dir_w;
  assign eng_prd_addr = ptr_w;
  assign bm_active    = act_w;

  p_active_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bm_active == sts_w[STS_ACT]);
  p_ptr_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_prd_addr[1:0] == 2'b00);
endmodule

// File: tb/bmdma_chan_regs_bench.sv
module bmdma_chan_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        simplex_mode = 1'b0;
  logic        eng_prd_fetched = 1'b0, eng_irq_evt = 1'b0, eng_err_evt = 1'b0, eng_done = 1'b0;
  logic        eng_start, eng_abort, eng_dir, bm_active;
  logic [31:0] eng_prd_addr;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  typedef struct {
    logic [2:0]  addr;
    logic [31:0] exp;
    string       req;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #5 clk = ~clk;

  bmdma_chan_regs u_bmdma_chan_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .simplex_mode(simplex_mode), .eng_prd_fetched(eng_prd_fetched),
    .eng_irq_evt(eng_irq_evt), .eng_err_evt(eng_err_evt), .eng_done(eng_done),
    .eng_start(eng_start), .eng_abort(eng_abort), .eng_dir(eng_dir),
    .eng_prd_addr(eng_prd_addr), .bm_active(bm_active)
  );

  // Monitor: pops expected reads and compares them against the port
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      reg_addr = sb_q[0].addr;
      #1;
      checks++;
      if (reg_rdata !== sb_q[0].exp) begin
        errors++;
        $display("FAIL %s: read @%0h got %08h expected %08h",
                 sb_q[0].req, sb_q[0].addr, reg_rdata, sb_q[0].exp);
      end
      void'(sb_q.pop_front());
    end
  end

  // Driver side: push an expected read and wait for the monitor to consume it
  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string r);
    rd_item_t it;
    it.addr = a; it.exp = e; it.req = r;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string r);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", r, got, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic pulse_fetch();
    @(negedge clk); eng_prd_fetched = 1'b1; @(negedge clk); eng_prd_fetched = 1'b0;
  endtask
  task automatic pulse_irq();
    @(negedge clk); eng_irq_evt = 1'b1; @(negedge clk); eng_irq_evt = 1'b0;
  endtask
  task automatic pulse_err();
    @(negedge clk); eng_err_evt = 1'b1; @(negedge clk); eng_err_evt = 1'b0;
  endtask
  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_rd(3'd0, 32'h0, "R1");
    expect_rd(3'd4, 32'h0, "R1");
    chk({28'h0, eng_start, eng_abort, eng_dir, bm_active}, 32'h0, "R1 outputs");

    // R2/R9: reserved bits, unused bytes, drive flags; bit0/bit7 not writable
    wr(3'd0, 4'hF, 32'hFFFF_FFFE);
    expect_rd(3'd0, 32'h0060_0008, "R2 R9 readback");
    chk({31'h0, eng_start}, 32'h0, "R2 no start without enable");

    // R10: alignment and byte-enabled writes
    wr(3'd4, 4'hF, 32'h1000_0007);
    expect_rd(3'd4, 32'h1000_0004, "R10 aligned");
    wr(3'd4, 4'b0010, 32'hFFFF_ABFF);
    expect_rd(3'd4, 32'h1000_AB04, "R10 partial");

    // R3: start
    wr(3'd0, 4'b0001, 32'h0000_0009);
    chk({30'h0, eng_start, bm_active}, 32'h3, "R3 start pulse and active");
    chk({31'h0, eng_dir}, 32'h1, "R3 direction");
    @(negedge clk);
    chk({31'h0, eng_start}, 32'h0, "R3 one cycle");
    expect_rd(3'd0, 32'h0061_0009, "R3 status active");

    // R6: direction frozen while active
    wr(3'd0, 4'b0001, 32'h0000_0001);
    expect_rd(3'd0, 32'h0061_0009, "R6 dir held");
    chk({31'h0, eng_start}, 32'h0, "R6 no second start");

    // R11: advances
    pulse_fetch();
    chk(eng_prd_addr, 32'h1000_AB0C, "R11 first step");
    pulse_fetch();
    expect_rd(3'd4, 32'h1000_AB14, "R11 second step");

    // R7: event flags
    pulse_irq();
    expect_rd(3'd0, 32'h0065_0009, "R7 irq set");
    pulse_err();
    expect_rd(3'd0, 32'h0067_0009, "R7 err set");
    wr(3'd0, 4'b0100, 32'h0060_0000);
    expect_rd(3'd0, 32'h0067_0009, "R7 write 0 keeps");
    wr(3'd0, 4'b0100, 32'h0064_0000);
    expect_rd(3'd0, 32'h0063_0009, "R7 irq cleared");

    // R8: set wins over clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_be = 4'b0100; reg_wdata = 32'h0062_0000;
    eng_err_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; eng_err_evt = 1'b0;
    expect_rd(3'd0, 32'h0063_0009, "R8 set wins");
    wr(3'd0, 4'b0100, 32'h0062_0000);
    expect_rd(3'd0, 32'h0061_0009, "R7 err cleared");

    // R5: completion
    pulse_done();
    chk({31'h0, bm_active}, 32'h0, "R5 inactive");
    expect_rd(3'd0, 32'h0060_0009, "R5 enable kept");
    pulse_fetch();
    chk(eng_prd_addr, 32'h1000_AB14, "R11 ignored when inactive");

    // R6: writable when idle
    wr(3'd0, 4'b0001, 32'h0000_0001);
    expect_rd(3'd0, 32'h0060_0001, "R6 dir writable idle");

    // R4: abort and restart
    wr(3'd0, 4'b0001, 32'h0000_0000);
    chk({31'h0, eng_abort}, 32'h1, "R4 abort on disable");
    wr(3'd0, 4'b0001, 32'h0000_0001);
    chk({30'h0, eng_start, bm_active}, 32'h3, "R4 restart");
    pulse_fetch();
    chk(eng_prd_addr, 32'h1000_AB1C, "R11 step in new run");
    wr(3'd0, 4'b0001, 32'h0000_0000);
    chk({30'h0, eng_abort, bm_active}, 32'h2, "R4 abort clears active");
    @(negedge clk);
    chk({31'h0, eng_abort}, 32'h0, "R4 abort one cycle");
    wr(3'd0, 4'b0001, 32'h0000_0001);
    chk(eng_prd_addr, 32'h1000_AB1C, "R4 resumes at current pointer");
    chk({31'h0, bm_active}, 32'h1, "R4 active again");

    // R9: simplex reflected, R2 unused bytes ignore writes
    simplex_mode = 1'b1;
    wr(3'd0, 4'b1010, 32'hFFFF_FFFF);
    expect_rd(3'd0, 32'h00E1_0001, "R9 simplex R2 unused bytes");

    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule